// File: doc/BRIEF.md
# Byte Arithmetic Unit with Status Flags

This block is an 8-bit arithmetic and logic engine for an accumulator-based processor core. It holds an accumulator, a second data register for wide results, and a status byte. Each cycle it can perform one operation on the accumulator and an operand byte. The operations are load, add, add with carry, subtract with borrow, the three bitwise logic functions, rotation through the carry bit, an 8x8 multiply and an 8/8 divide. The block drives the carry, half-carry and signed-overflow flags from the result of each operation.

The parity bit is not stored. It is always the odd parity of the accumulator as it stands, so it changes in the same cycle as the accumulator. Software can write the status byte directly. That write sets two user flags and a two-bit field that picks one of four working register banks, and the bank field is also driven out on a port of its own. Instruction decoding and memory access are left to the surrounding core.

Top module: `byte_alu_status`

## Requirements
- R1: After reset the accumulator, the B register and every status bit read zero, and the bank select reads 0.
- R2: Operation code 2 sets A to A+operand and code 3 sets A to A+operand+CY. CY (status bit 7) becomes the carry out of bit 7.
- R3: For add, add-with-carry and subtract, AC (status bit 6) becomes 1 exactly when the low nibble carries into, or borrows from, the high nibble.
- R4: For add, add-with-carry and subtract, OV (status bit 2) becomes 1 exactly when the two's-complement result falls outside -128..127.
- R5: Operation code 4 sets A to A-operand-CY, and CY becomes 1 when that subtraction needs a borrow.
- R6: Operation codes 5, 6 and 7 set A to A AND, OR or XOR the operand. CY, AC and OV keep their values.
- R7: Code 8 rotates {CY,A} left, so CY takes old A[7] and A[0] takes old CY. Code 9 rotates right, so CY takes old A[0] and A[7] takes old CY. AC and OV are unchanged.
- R8: Code 10 writes the low product byte of A*operand to A and the high byte to B. It clears CY and sets OV exactly when the high byte is nonzero.
- R9: Code 11 writes the quotient of A/operand to A and the remainder to B, and clears CY and OV. With a zero operand, A and B keep their values, OV is set and CY is cleared.
- R10: Status bit 0 always equals the XOR of the accumulator bits. A status write cannot change it.
- R11: A status write sets F0 (bit 5), RS1:RS0 (bits 4:3) and F1 (bit 1) from the written byte, and bank_o follows RS1:RS0. The write also sets CY, AC and OV, except those bits that an operation in the same cycle updates; for those bits the operation's value wins.
- R12: Code 1 loads the operand into A with the flags unchanged. Code 0 and codes 12 to 15 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Perform op_code this cycle |
| op_code | input | 4 | Operation select |
| opnd_i | input | 8 | Operand byte |
| psw_wr | input | 1 | Software write of the status byte |
| psw_wdata | input | 8 | Status byte to write |
| acc_o | output | 8 | Accumulator |
| b_o | output | 8 | High product / remainder register |
| psw_o | output | 8 | Status byte CY,AC,F0,RS1,RS0,OV,F1,P |
| bank_o | output | 2 | Working register bank select |

## Verification
A software write of the status byte and a flag-producing operation can arrive in the same cycle. Both then target CY, AC and OV. The bench asserts psw_wr together with an add, a logic operation and a rotate. For each case it checks which source set each flag: the operation's flags where that operation owns them, and the written bits everywhere else. The user and bank bits are checked at the same time.

// File: rtl/byte_alu_pkg.sv
package byte_alu_pkg;
    parameter int unsigned BYTE_W = 8;
    localparam int unsigned NIB_W = BYTE_W / 2;

    typedef enum logic [3:0] {
        OP_NOP  = 4'd0,
        OP_LOAD = 4'd1,
        OP_ADD  = 4'd2,
        OP_ADDC = 4'd3,
        OP_SUBB = 4'd4,
        OP_AND  = 4'd5,
        OP_OR   = 4'd6,
        OP_XOR  = 4'd7,
        OP_RLC  = 4'd8,
        OP_RRC  = 4'd9,
        OP_MUL  = 4'd10,
        OP_DIV  = 4'd11
    } alu_op_e;

    typedef struct packed {
        logic [BYTE_W-1:0] acc;
        logic [BYTE_W-1:0] breg;
        logic              cy;
        logic              ac;
        logic              f0;
        logic [1:0]        rs;
        logic              ov;
        logic              f1;
    } alu_state_t;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub
    import byte_alu_pkg::*;
(
    input  logic [BYTE_W-1:0] a_i,
    input  logic [BYTE_W-1:0] b_i,
    input  logic              cin_i,
    input  logic              sub_i,
    output logic [BYTE_W-1:0] sum_o,
    output logic              cy_o,
    output logic              ac_o,
    output logic              ov_o
);
    logic [BYTE_W-1:0] b_x;
    logic              c_x;
    logic              c_nib;
    logic              c_top;
    logic              c_out;
    logic [NIB_W-1:0]  unused_nib;
    logic [BYTE_W-2:0] unused_low;

    // Subtract as a + ~b + ~borrow; carries become inverted borrows.
    assign b_x = sub_i ? ~b_i : b_i;
    assign c_x = sub_i ? ~cin_i : cin_i;

    assign {c_nib, unused_nib} = {1'b0, a_i[NIB_W-1:0]} + {1'b0, b_x[NIB_W-1:0]}
                               + {{NIB_W{1'b0}}, c_x};
    assign {c_top, unused_low} = {1'b0, a_i[BYTE_W-2:0]} + {1'b0, b_x[BYTE_W-2:0]}
                               + {{(BYTE_W-1){1'b0}}, c_x};
    assign {c_out, sum_o}      = {1'b0, a_i} + {1'b0, b_x} + {{BYTE_W{1'b0}}, c_x};

    assign cy_o = sub_i ? ~c_out : c_out;
    assign ac_o = sub_i ? ~c_nib : c_nib;
    assign ov_o = c_top ^ c_out;
endmodule

// File: rtl/alu_logic_rot.sv
module alu_logic_rot
    import byte_alu_pkg::*;
(
    input  alu_op_e           op_i,
    input  logic [BYTE_W-1:0] a_i,
    input  logic [BYTE_W-1:0] b_i,
    input  logic              cin_i,
    output logic [BYTE_W-1:0] res_o,
    output logic              cy_o
);
    always_comb begin
        res_o = a_i;
        cy_o  = cin_i;
        case (op_i)
            OP_AND: res_o = a_i & b_i;
            OP_OR:  res_o = a_i | b_i;
            OP_XOR: res_o = a_i ^ b_i;
            OP_RLC: begin
                res_o = {a_i[BYTE_W-2:0], cin_i};
                cy_o  = a_i[BYTE_W-1];
            end
            OP_RRC: begin
                res_o = {cin_i, a_i[BYTE_W-1:1]};
                cy_o  = a_i[0];
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/alu_muldiv.sv
module alu_muldiv
    import byte_alu_pkg::*;
(
    input  logic [BYTE_W-1:0] a_i,
    input  logic [BYTE_W-1:0] b_i,
    output logic [BYTE_W-1:0] prod_lo_o,
    output logic [BYTE_W-1:0] prod_hi_o,
    output logic [BYTE_W-1:0] quot_o,
    output logic [BYTE_W-1:0] rem_o,
    output logic              mul_ov_o,
    output logic              div_zero_o
);
    localparam int unsigned PROD_W = 2 * BYTE_W;
    logic [PROD_W-1:0] prod;

    assign prod       = {{BYTE_W{1'b0}}, a_i} * {{BYTE_W{1'b0}}, b_i};
    assign prod_lo_o  = prod[BYTE_W-1:0];
    assign prod_hi_o  = prod[PROD_W-1:BYTE_W];
    assign mul_ov_o   = |prod_hi_o;
    assign div_zero_o = (b_i == '0);
    // Guarded so a zero divisor yields a defined value; the top holds A and B then.
    assign quot_o     = div_zero_o ? '0 : a_i / b_i;
    assign rem_o      = div_zero_o ? '0 : a_i % b_i;
endmodule

// File: rtl/byte_alu_status.sv
module byte_alu_status
    import byte_alu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [3:0]        op_code,
    input  logic [BYTE_W-1:0] opnd_i,
    input  logic              psw_wr,
    input  logic [BYTE_W-1:0] psw_wdata,
    output logic [BYTE_W-1:0] acc_o,
    output logic [BYTE_W-1:0] b_o,
    output logic [BYTE_W-1:0] psw_o,
    output logic [1:0]        bank_o
);
    localparam int unsigned CY_POS = BYTE_W - 1;
    localparam int unsigned AC_POS = BYTE_W - 2;
    localparam int unsigned F0_POS = BYTE_W - 3;
    localparam int unsigned RS_HI  = BYTE_W - 4;
    localparam int unsigned RS_LO  = BYTE_W - 5;
    localparam int unsigned OV_POS = 2;
    localparam int unsigned F1_POS = 1;

    alu_state_t s_q, s_d;
    alu_op_e    op;

    logic [BYTE_W-1:0] as_sum, lr_res, m_lo, m_hi, d_q, d_r;
    logic              as_cy, as_ac, as_ov, lr_cy, m_ov, d_zero, is_sub, cin;
    logic              unused_wp;

    assign op        = alu_op_e'(op_code);
    assign is_sub    = (op == OP_SUBB);
    assign cin       = (op == OP_ADD) ? 1'b0 : s_q.cy;
    assign unused_wp = psw_wdata[0];

    alu_addsub u_addsub (
        .a_i(s_q.acc), .b_i(opnd_i), .cin_i(cin), .sub_i(is_sub),
        .sum_o(as_sum), .cy_o(as_cy), .ac_o(as_ac), .ov_o(as_ov)
    );

    alu_logic_rot u_logic (
        .op_i(op), .a_i(s_q.acc), .b_i(opnd_i), .cin_i(s_q.cy),
        .res_o(lr_res), .cy_o(lr_cy)
    );

    alu_muldiv u_muldiv (
        .a_i(s_q.acc), .b_i(opnd_i),
        .prod_lo_o(m_lo), .prod_hi_o(m_hi), .quot_o(d_q), .rem_o(d_r),
        .mul_ov_o(m_ov), .div_zero_o(d_zero)
    );

    // Software write first; the operation then overrides the flags it owns.
    always_comb begin
        s_d = s_q;
        if (psw_wr) begin
            s_d.cy = psw_wdata[CY_POS];
            s_d.ac = psw_wdata[AC_POS];
            s_d.f0 = psw_wdata[F0_POS];
            s_d.rs = psw_wdata[RS_HI:RS_LO];
            s_d.ov = psw_wdata[OV_POS];
            s_d.f1 = psw_wdata[F1_POS];
        end
        if (op_valid) begin
            case (op)
                OP_LOAD: s_d.acc = opnd_i;
                OP_ADD, OP_ADDC, OP_SUBB: begin
                    s_d.acc = as_sum;
                    s_d.cy  = as_cy;
                    s_d.ac  = as_ac;
                    s_d.ov  = as_ov;
                end
                OP_AND, OP_OR, OP_XOR: s_d.acc = lr_res;
                OP_RLC, OP_RRC: begin
                    s_d.acc = lr_res;
                    s_d.cy  = lr_cy;
                end
                OP_MUL: begin
                    s_d.acc  = m_lo;
                    s_d.breg = m_hi;
                    s_d.cy   = 1'b0;
                    s_d.ov   = m_ov;
                end
                OP_DIV: begin
                    if (!d_zero) begin
                        s_d.acc  = d_q;
                        s_d.breg = d_r;
                    end
                    s_d.cy = 1'b0;
                    s_d.ov = d_zero;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign acc_o  = s_q.acc;
    assign b_o    = s_q.breg;
    assign bank_o = s_q.rs;
    assign psw_o  = {s_q.cy, s_q.ac, s_q.f0, s_q.rs, s_q.ov, s_q.f1, ^s_q.acc};

    AST_ADD_SUM: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 4'd2) |=>
        ({psw_o[CY_POS], acc_o} == ({1'b0, $past(acc_o)} + {1'b0, $past(opnd_i)}))); // R2
    AST_LOGIC_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code >= 4'd5 && op_code <= 4'd7 && !psw_wr) |=>
        $stable({psw_o[CY_POS], psw_o[AC_POS], psw_o[OV_POS]})); // R6
    AST_RLC_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 4'd8) |=> (psw_o[CY_POS] == $past(acc_o[BYTE_W-1]))); // R7
    AST_MUL_CLEARS_CY: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 4'd10) |=> !psw_o[CY_POS]); // R8
    AST_DIV_ZERO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 4'd11 && opnd_i == '0) |=>
        (psw_o[OV_POS] && !psw_o[CY_POS] && acc_o == $past(acc_o) && b_o == $past(b_o))); // R9
    AST_USER_BITS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        psw_wr |=> ({psw_o[F0_POS], bank_o, psw_o[F1_POS]} ==
                    {$past(psw_wdata[F0_POS]), $past(psw_wdata[RS_HI:RS_LO]),
                     $past(psw_wdata[F1_POS])})); // R11
endmodule

// File: tb/byte_alu_status_tb.sv
module byte_alu_status_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic [3:0] op_code = 4'd0;
    logic [7:0] opnd_i = 8'h00;
    logic       psw_wr = 1'b0;
    logic [7:0] psw_wdata = 8'h00;
    logic [7:0] acc_o, b_o, psw_o;
    logic [1:0] bank_o;
    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    byte_alu_status u_dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .opnd_i(opnd_i), .psw_wr(psw_wr), .psw_wdata(psw_wdata),
        .acc_o(acc_o), .b_o(b_o), .psw_o(psw_o), .bank_o(bank_o)
    );

    task automatic apply(input logic v, input logic [3:0] code, input logic [7:0] d,
                         input logic w, input logic [7:0] wd);
        op_valid = v; op_code = code; opnd_i = d; psw_wr = w; psw_wdata = wd;
        @(negedge clk);
        op_valid = 1'b0; psw_wr = 1'b0;
    endtask

    task automatic op(input logic [3:0] code, input logic [7:0] d);
        apply(1'b1, code, d, 1'b0, 8'h00);
    endtask

    task automatic wr(input logic [7:0] wd);
        apply(1'b0, 4'd0, 8'h00, 1'b1, wd);
    endtask

    task automatic check(input string req, input logic [7:0] ea, input logic [7:0] eb,
                         input logic [7:0] ep);
        checks++;
        if (acc_o !== ea || b_o !== eb || psw_o !== ep) begin
            fails++;
            $display("FAIL %s acc=%h b=%h psw=%h expected acc=%h b=%h psw=%h",
                     req, acc_o, b_o, psw_o, ea, eb, ep);
        end
    endtask

    task automatic check_bank(input string req, input logic [1:0] eb);
        checks++;
        if (bank_o !== eb) begin
            fails++;
            $display("FAIL %s bank=%0d expected bank=%0d", req, bank_o, eb);
        end
    endtask

    task automatic t_reset;
        check("R1 reset", 8'h00, 8'h00, 8'h00);
        check_bank("R1 reset bank", 2'd0);
    endtask

    task automatic t_load;
        op(4'd1, 8'h7F); check("R12 load / R10 parity", 8'h7F, 8'h00, 8'h01);
    endtask

    task automatic t_add;
        op(4'd2, 8'h01); check("R2 R3 R4 add 7F+01", 8'h80, 8'h00, 8'h45);
        op(4'd2, 8'h80); check("R2 R4 add 80+80", 8'h00, 8'h00, 8'h84);
        op(4'd3, 8'h0F); check("R2 R3 addc 00+0F+1", 8'h10, 8'h00, 8'h41);
    endtask

    task automatic t_sub;
        op(4'd4, 8'h01); check("R5 R3 subb 10-01", 8'h0F, 8'h00, 8'h40);
        op(4'd4, 8'h10); check("R5 subb 0F-10 borrow", 8'hFF, 8'h00, 8'h80);
        op(4'd4, 8'h7F); check("R5 R4 subb FF-7F-1", 8'h7F, 8'h00, 8'h45);
    endtask

    task automatic t_logic;
        op(4'd7, 8'hFF); check("R6 xor", 8'h80, 8'h00, 8'h45);
        op(4'd5, 8'h00); check("R6 and", 8'h00, 8'h00, 8'h44);
        op(4'd6, 8'h03); check("R6 or", 8'h03, 8'h00, 8'h44);
    endtask

    task automatic t_rotate;
        op(4'd1, 8'h81); wr(8'h80); check("R11 set CY", 8'h81, 8'h00, 8'h80);
        op(4'd8, 8'h00); check("R7 rlc", 8'h03, 8'h00, 8'h80);
        op(4'd9, 8'h00); check("R7 rrc", 8'h81, 8'h00, 8'h80);
        op(4'd9, 8'h00); check("R7 rrc again", 8'hC0, 8'h00, 8'h80);
        wr(8'h00);
        op(4'd8, 8'h00); check("R7 rlc cin 0", 8'h80, 8'h00, 8'h81);
    endtask

    task automatic t_mul;
        op(4'd1, 8'h10);
        op(4'd10, 8'h20); check("R8 mul high byte", 8'h00, 8'h02, 8'h04);
        wr(8'h80); op(4'd1, 8'h0C);
        op(4'd10, 8'h05); check("R8 mul small, CY cleared", 8'h3C, 8'h00, 8'h00);
    endtask

    task automatic t_div;
        op(4'd1, 8'hFB);
        op(4'd11, 8'h12); check("R9 div 251/18", 8'h0D, 8'h11, 8'h01);
        wr(8'h80);
        op(4'd11, 8'h00); check("R9 div by zero", 8'h0D, 8'h11, 8'h05);
    endtask

    task automatic t_psw_write;
        wr(8'hFF); check("R11 write all ones", 8'h0D, 8'h11, 8'hFF);
        check_bank("R11 bank 3", 2'd3);
        wr(8'h00); check("R11 R10 write zero, P from A", 8'h0D, 8'h11, 8'h01);
        check_bank("R11 bank 0", 2'd0);
        op(4'd1, 8'h03);
        wr(8'h01); check("R10 P not writable", 8'h03, 8'h11, 8'h00);
    endtask

    task automatic t_collide;
        apply(1'b1, 4'd2, 8'hFD, 1'b1, 8'h3A);
        check("R11 add owns flags on write", 8'h00, 8'h11, 8'hFA);
        check_bank("R11 collide bank", 2'd3);
        apply(1'b1, 4'd7, 8'h01, 1'b1, 8'hC4);
        check("R11 R6 logic lets write set flags", 8'h01, 8'h11, 8'hC5);
        apply(1'b1, 4'd8, 8'h00, 1'b1, 8'h44);
        check("R11 R7 rotate owns CY only", 8'h03, 8'h11, 8'h44);
        op(4'd15, 8'hAA); check("R12 undefined code no effect", 8'h03, 8'h11, 8'h44);
        op(4'd0, 8'h55); check("R12 nop no effect", 8'h03, 8'h11, 8'h44);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_load();
        t_add();
        t_sub();
        t_logic();
        t_rotate();
        t_mul();
        t_div();
        t_psw_write();
        t_collide();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule